// File: doc/BRIEF.md
# Single-Channel Descriptor DMA Controller

This block is the control and status engine of one channel of a scatter-gather DMA. Software loads the address of the first descriptor while the channel is halted and sets the run bit. It then writes a tail pointer, and that write starts the walk. For each descriptor the engine reads the next pointer and the control word from memory. It hands the byte length to the data mover, which is modelled here as a fixed-latency done pulse. It then writes a completion status back into the descriptor and follows the next pointer. The walk stops once the descriptor whose address equals the tail has completed.

Each descriptor is sixteen 32-bit words and starts on a 128-byte boundary. A descriptor whose next pointer holds its own address forms a one-entry ring, and every tail write runs it once more. Software clears the completion flag with a write-one-to-clear, masks the interrupt line per flag, stops the channel gracefully through the run bit, or aborts everything with a self-clearing soft reset.

Top module: `sdma_chan`

## Requirements
- R1: After reset, control (word 0) reads 0, status (word 1) reads 0x1, the current pointer (word 2) and the tail pointer (word 4) read 0, irq_o is low, and mem_req_o is low.
- R2: The register words are indexed by reg_addr_i: 0 is control, 1 is status, 2 is the current pointer, 3 always reads 0, and 4 is the tail pointer. A write to the current pointer takes effect only while status bit 0 (halted) is 1. At any other time it is ignored.
- R3: A tail write while run (control bit 0) is 0 only stores the pointer. Setting run afterwards issues no memory request until the tail is written again with run set.
- R4: Descriptors are aligned to 128 bytes. For each descriptor the engine reads word 0 (the next pointer, byte offset 0x00) and word 6 (control, offset 0x18), and takes the byte length from bits 25:0 of the control word. It waits XFER_LAT cycles for the mover, then writes word 7 (offset 0x1C) with bit 31 set and the length in bits 25:0.
- R5: Each descriptor completion sets status bit 12. Writing a 1 to any of status bits 14:12 clears that bit, and writing a 0 leaves it unchanged.
- R6: The engine follows next pointers and stops after completing the descriptor whose address equals the tail pointer. The current pointer then holds that descriptor's next pointer. A one-entry ring is processed again on each tail write while run is 1.
- R7: irq_o is the OR of status bits 14:12, each ANDed with the control bit in the same position.
- R8: mem_req_o stays high with mem_addr_o and mem_we_o unchanged until mem_ack_i is seen.
- R9: Clearing run in the middle of a walk lets the descriptor in progress complete. No further descriptor is started, and status bit 0 then reads 1.
- R10: Writing control with bit 2 set drops mem_req_o on the next cycle and clears all registers. Control bit 2 reads 1 for RST_CYCLES cycles and then clears by itself. Status bit 0 reads 1 throughout, and register writes are ignored while the reset is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mem_req_o | output | 1 | Descriptor memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the descriptor word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted (read data valid) |
| mem_rdata_i | input | 32 | Read data |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest states to reach are the two ways of leaving a walk early. A run clear has to land while a descriptor is in its mover wait, and a soft reset has to land while a memory request is still waiting for its acknowledge. The bench counts cycles from the tail write through the registered acknowledge of its memory model, so that each control write falls inside the intended phase of a two- or three-descriptor chain. It then checks which descriptor status words were rewritten and which kept their preloaded value.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [2:0] {
    WK_IDLE, WK_RD_NEXT, WK_RD_CTRL, WK_MOVE, WK_WR_STAT
  } walk_st_e;

  localparam int RG_CTRL = 0;
  localparam int RG_STAT = 1;
  localparam int RG_CUR  = 2;
  localparam int RG_TAIL = 4;

  localparam int CB_RUN  = 0;
  localparam int CB_RST  = 2;
  localparam int IRQ_LO  = 12;
  localparam int IRQ_N   = 3;

  // descriptor word indices
  localparam int DW_NEXT = 0;
  localparam int DW_CTRL = 6;
  localparam int DW_STAT = 7;
endpackage

// File: rtl/sdma_mover_model.sv
module sdma_mover_model #(
  parameter int XFER_LAT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = $clog2(XFER_LAT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (start_i)            cnt_q <= CW'(XFER_LAT);
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/sdma_walker.sv
module sdma_walker
  import sdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          kick_i,
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] tail_i,
  output logic          busy_o,
  output logic          cplt_o,
  output logic [AW-1:0] cur_nxt_o,
  output logic          mv_start_o,
  input  logic          mv_done_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i
);
  localparam logic [AW-1:0] OFS_NEXT = AW'(DW_NEXT * 4);
  localparam logic [AW-1:0] OFS_CTRL = AW'(DW_CTRL * 4);
  localparam logic [AW-1:0] OFS_STAT = AW'(DW_STAT * 4);

  walk_st_e         st_q;
  logic             go_q;
  logic [AW-1:0]    desc_q, next_q;
  logic [LEN_W-1:0] len_q;
  logic             last_c;

  assign last_c = (desc_q == tail_i) || !run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= WK_IDLE; go_q <= 1'b0;
      desc_q <= '0; next_q <= '0; len_q <= '0;
    end else if (clr_i) begin
      st_q <= WK_IDLE; go_q <= 1'b0;
    end else begin
      if (kick_i) go_q <= 1'b1;
      unique case (st_q)
        WK_IDLE: if (go_q && run_i) begin
          desc_q <= cur_i;
          st_q   <= WK_RD_NEXT;
        end
        WK_RD_NEXT: if (mem_ack_i) begin
          next_q <= mem_rdata_i[AW-1:0];
          st_q   <= WK_RD_CTRL;
        end
        WK_RD_CTRL: if (mem_ack_i) begin
          len_q <= mem_rdata_i[LEN_W-1:0];
          st_q  <= WK_MOVE;
        end
        WK_MOVE: if (mv_done_i) st_q <= WK_WR_STAT;
        WK_WR_STAT: if (mem_ack_i) begin
          if (last_c) begin
            st_q <= WK_IDLE;
            if (!kick_i) go_q <= 1'b0;
          end else begin
            desc_q <= next_q;
            st_q   <= WK_RD_NEXT;
          end
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr_o = desc_q + OFS_NEXT;
    if (st_q == WK_RD_CTRL) mem_addr_o = desc_q + OFS_CTRL;
    if (st_q == WK_WR_STAT) mem_addr_o = desc_q + OFS_STAT;
  end

  assign mem_req_o   = (st_q == WK_RD_NEXT) || (st_q == WK_RD_CTRL) || (st_q == WK_WR_STAT);
  assign mem_we_o    = (st_q == WK_WR_STAT);
  assign mem_wdata_o = {1'b1, {(31 - LEN_W){1'b0}}, len_q};
  assign mv_start_o  = (st_q == WK_RD_CTRL) && mem_ack_i && !clr_i;
  assign busy_o      = (st_q != WK_IDLE);
  assign cplt_o      = (st_q == WK_WR_STAT) && mem_ack_i && !clr_i;
  assign cur_nxt_o   = next_q;

  logic unused_rd;
  assign unused_rd = ^mem_rdata_i[31:LEN_W];
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int REG_AW     = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              cplt_i,
  input  logic [AW-1:0]     cur_nxt_i,
  output logic              run_o,
  output logic              kick_o,
  output logic              clr_o,
  output logic [AW-1:0]     cur_o,
  output logic [AW-1:0]     tail_o,
  output logic              halted_o,
  output logic [IRQ_N-1:0]  flag_o,
  output logic [IRQ_N-1:0]  ien_o
);
  localparam int RCW = $clog2(RST_CYCLES + 1);

  logic             run_q;
  logic [IRQ_N-1:0] ien_q, flag_q;
  logic [AW-1:0]    cur_q, tail_q;
  logic [RCW-1:0]   rcnt_q;
  logic             rst_act, wr_ok, srst_req;

  assign rst_act  = (rcnt_q != '0);
  assign wr_ok    = reg_wr_i && !rst_act;
  assign srst_req = wr_ok && (reg_addr_i == REG_AW'(RG_CTRL)) && reg_wdata_i[CB_RST];
  assign halted_o = rst_act || (!run_q && !busy_i);
  assign kick_o   = wr_ok && (reg_addr_i == REG_AW'(RG_TAIL)) && run_q;
  assign clr_o    = srst_req || rst_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; ien_q <= '0; flag_q <= '0;
      cur_q <= '0; tail_q <= '0; rcnt_q <= '0;
    end else if (srst_req) begin
      run_q <= 1'b0; ien_q <= '0; flag_q <= '0;
      cur_q <= '0; tail_q <= '0; rcnt_q <= RCW'(RST_CYCLES);
    end else begin
      if (rst_act) rcnt_q <= rcnt_q - 1'b1;
      if (wr_ok && reg_addr_i == REG_AW'(RG_CTRL)) begin
        run_q <= reg_wdata_i[CB_RUN];
        ien_q <= reg_wdata_i[IRQ_LO +: IRQ_N];
      end
      if (wr_ok && reg_addr_i == REG_AW'(RG_TAIL)) tail_q <= reg_wdata_i[AW-1:0];
      if (cplt_i) cur_q <= cur_nxt_i;
      else if (wr_ok && reg_addr_i == REG_AW'(RG_CUR) && halted_o) cur_q <= reg_wdata_i[AW-1:0];
      // set wins over a clear in the same cycle
      for (int i = 0; i < IRQ_N; i++) begin
        if (i == 0 && cplt_i)
          flag_q[i] <= 1'b1;
        else if (wr_ok && reg_addr_i == REG_AW'(RG_STAT) && reg_wdata_i[IRQ_LO + i])
          flag_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_AW'(RG_CTRL): begin
        reg_rdata_o[CB_RUN] = run_q;
        reg_rdata_o[CB_RST] = rst_act;
        reg_rdata_o[IRQ_LO +: IRQ_N] = ien_q;
      end
      REG_AW'(RG_STAT): begin
        reg_rdata_o[0] = halted_o;
        reg_rdata_o[IRQ_LO +: IRQ_N] = flag_q;
      end
      REG_AW'(RG_CUR):  reg_rdata_o[AW-1:0] = cur_q;
      REG_AW'(RG_TAIL): reg_rdata_o[AW-1:0] = tail_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign run_o  = run_q;
  assign cur_o  = cur_q;
  assign tail_o = tail_q;
  assign flag_o = flag_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/sdma_chan.sv
module sdma_chan
  import sdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int REG_AW     = 3,
  parameter int LEN_W      = 26,
  parameter int XFER_LAT   = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              irq_o
);
  logic             run, kick, clr, busy, cplt, halted, mv_start, mv_done;
  logic [AW-1:0]    cur, tail, cur_nxt;
  logic [IRQ_N-1:0] flag, ien;

  sdma_regs #(.AW(AW), .REG_AW(REG_AW), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .cplt_i(cplt), .cur_nxt_i(cur_nxt),
    .run_o(run), .kick_o(kick), .clr_o(clr), .cur_o(cur), .tail_o(tail),
    .halted_o(halted), .flag_o(flag), .ien_o(ien)
  );

  sdma_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk_i, .rst_ni, .clr_i(clr), .run_i(run), .kick_i(kick),
    .cur_i(cur), .tail_i(tail), .busy_o(busy), .cplt_o(cplt),
    .cur_nxt_o(cur_nxt), .mv_start_o(mv_start), .mv_done_i(mv_done),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  sdma_mover_model #(.XFER_LAT(XFER_LAT)) u_mover (
    .clk_i, .rst_ni, .clr_i(clr), .start_i(mv_start), .done_o(mv_done)
  );

  assign irq_o = |(flag & ien);
endmodule

// File: rtl/sdma_chan_chk.sv
module sdma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          clr,
  input logic          cplt,
  input logic          halted,
  input logic [2:0]    flag
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || clr)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R8
  AST_ABORT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !mem_req_o); // R10
  AST_WB_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[31] && (mem_addr_o[6:0] == 7'h1c)); // R4
  AST_CPLT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni || clr)
    cplt |=> flag[0]); // R5
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted |-> !mem_req_o); // R9
endmodule

bind sdma_chan sdma_chan_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .clr(clr), .cplt(cplt), .halted(halted), .flag(flag)
);

// File: tb/sdma_chan_test.sv
`timescale 1ns/1ps
module sdma_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        pl_we = 1'b0;
  logic [7:0]  pl_idx = '0;
  logic [31:0] pl_data = '0;
  logic [31:0] mem [0:255];
  int n_chk = 0, n_fail = 0, hold_viol = 0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdma_chan #(.RST_CYCLES(RST_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .irq_o(irq)
  );

  // memory model: one-cycle registered acknowledge
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (pl_we) mem[pl_idx] <= pl_data;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  // handshake monitor for R8
  always @(posedge clk) begin
    if (rst_n && prev_wait && (!mem_req || mem_addr != prev_addr)) hold_viol++;
    prev_wait <= mem_req && !mem_ack && !reg_wr;
    prev_addr <= mem_addr;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 3'(a); #1 d = reg_rdata;
  endtask

  task automatic poke(input int idx, input logic [31:0] d);
    @(negedge clk); pl_we = 1'b1; pl_idx = 8'(idx); pl_data = d;
    @(negedge clk); pl_we = 1'b0;
  endtask

  task automatic desc(input int base, input logic [31:0] nxt, input logic [31:0] len);
    poke(base/4 + 0, nxt);
    poke(base/4 + 6, 32'h0C00_0000 | len);
    poke(base/4 + 7, 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); check("R1 ctrl", d, 0);
    rd(1, d); check("R1 status", d, 32'h1);
    rd(2, d); check("R1 cur", d, 0);
    rd(4, d); check("R1 tail", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 req", {31'b0, mem_req}, 0);
  endtask

  task automatic t_tail_halted;
    logic [31:0] d;
    desc(32'h80, 32'h80, 32'd100);
    wr(4, 32'h80);
    wr(0, 32'h1);
    idle(30);
    check("R3 desc untouched", mem[39], 0);
    rd(1, d); check("R3 status running idle", d, 0);
    rd(4, d); check("R2 tail stored", d, 32'h80);
    rd(3, d); check("R2 word3 zero", d, 0);
    wr(2, 32'h100);
    rd(2, d); check("R2 cur locked while running", d, 0);
    wr(0, 32'h0);
    wr(2, 32'h80);
    rd(2, d); check("R2 cur loads when halted", d, 32'h80);
  endtask

  task automatic t_single_ring;
    logic [31:0] d;
    wr(0, 32'h1);
    wr(4, 32'h80);
    idle(40);
    check("R4 status writeback", mem[39], 32'h8000_0064);
    rd(1, d); check("R5 flag set", d, 32'h1000);
    rd(2, d); check("R6 cur after ring", d, 32'h80);
    check("R7 irq masked", {31'b0, irq}, 0);
    wr(0, 32'h1001);
    check("R7 irq enabled", {31'b0, irq}, 1);
    wr(1, 32'h0000);
    rd(1, d); check("R5 zero write keeps flag", d, 32'h1000);
    wr(1, 32'h7000);
    rd(1, d); check("R5 w1c", d, 0);
    check("R7 irq after clear", {31'b0, irq}, 0);
    poke(39, 32'h0);
    wr(4, 32'h80);
    idle(40);
    check("R6 ring repeats", mem[39], 32'h8000_0064);
    check("R7 irq again", {31'b0, irq}, 1);
    wr(1, 32'h1000);
  endtask

  task automatic t_chain;
    logic [31:0] d;
    wr(0, 32'h0);
    desc(32'h100, 32'h180, 32'h10);
    desc(32'h180, 32'h200, 32'h20);
    desc(32'h200, 32'h100, 32'h30);
    wr(2, 32'h100);
    wr(0, 32'h1);
    wr(4, 32'h180);
    idle(80);
    check("R6 first", mem[71], 32'h8000_0010);
    check("R6 second", mem[103], 32'h8000_0020);
    check("R6 beyond tail", mem[135], 0);
    rd(2, d); check("R6 cur next", d, 32'h200);
    check("R8 request held", hold_viol, 0);
    wr(1, 32'h7000);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(0, 32'h0);
    poke(71, 0); poke(103, 0);
    wr(2, 32'h100);
    wr(0, 32'h1);
    wr(4, 32'h200);
    idle(6);
    wr(0, 32'h0);
    idle(60);
    check("R9 current finishes", mem[71], 32'h8000_0010);
    check("R9 next not started", mem[103], 0);
    rd(1, d); check("R9 halted", d & 32'h1, 1);
    rd(2, d); check("R9 cur", d, 32'h180);
  endtask

  task automatic t_soft_reset;
    logic [31:0] d;
    wr(2, 32'h100);
    wr(0, 32'h1);
    wr(4, 32'h200);
    idle(2);
    wr(0, 32'h5);
    check("R10 req dropped", {31'b0, mem_req}, 0);
    rd(0, d); check("R10 reset bit visible", d, 32'h4);
    wr(2, 32'h80);
    idle(RST_CYC + 2);
    rd(0, d); check("R10 self clear", d, 0);
    rd(1, d); check("R10 halted", d, 32'h1);
    rd(2, d); check("R10 cur cleared", d, 0);
    rd(4, d); check("R10 tail cleared", d, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tail_halted();
    t_single_ring();
    t_chain();
    t_stop();
    t_soft_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule